// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block measures how many master-clock cycles fit into each period of the audio word clock (the sample-rate clock) and decides which supported oversampling ratio the system runs at. The word clock arrives asynchronously. It is brought into the master-clock domain through a short flop chain, and each of its rising edges closes one measurement and opens the next. No configuration input is needed: the ratio is found automatically.

Six ratios are recognised. Four are normal rates: 256, 384, 512 and 768 clocks per sample. Two are high-rate modes: 128 and 192 clocks per sample, in which the downstream modulator runs at half its usual oversampling factor. A measured period is accepted as a ratio when it lies within a fixed tolerance of that ratio's nominal count.

A period that fits no ratio counts as a clock fault. So does a word clock that stops. On a fault the block drops lock and raises a mute request, which shuts the converter path down. The detected ratio is committed, and the mute request released, only after two consecutive periods agree.

Top module: `clkratio_detector`

## Requirements
- R1: After reset, `locked` is 0, `mute_req` is 1, `high_rate` is 0 and `ratio_code` is 7 (no ratio).
- R2: Ratio codes are 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768 master clocks per word-clock period. Code 7 means no ratio has been committed yet.
- R3: A period whose length is within ±8 master clocks of a nominal ratio (both ends included) classifies as that ratio.
- R4: A single period that is more than 8 clocks away from every nominal ratio clears `locked` and sets `mute_req`.
- R5: A ratio is committed to `ratio_code` only when two consecutive periods classify the same way. On that commit `locked` rises and `mute_req` falls. A lone period with a different valid class also clears `locked` and sets `mute_req`.
- R6: `high_rate` is 1 exactly when the committed code is 0 or 1 (128 or 192 clocks).
- R7: If no word-clock rising edge arrives for 2^CNT_W-1 master clocks, the period counter saturates and the block reports a fault, as in R4. The next rising edge also closes a saturated, faulty period.
- R8: While unlocked, `ratio_code` and `high_rate` keep the last committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock, asynchronous to clk |
| ratio_code | output | 3 | Committed ratio code (R2 encoding) |
| high_rate | output | 1 | Committed ratio is a high-rate mode |
| locked | output | 1 | Ratio committed and currently valid |
| mute_req | output | 1 | Request to shut down and mute the converter path |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, a tolerance of 8 and two synchroniser stages. With a 10-bit counter, saturation at 1023 clocks is reachable with a short stall. With a tolerance of 8, every window edge for all six ratios can be probed with periods of at most 776 clocks. Random periods are drawn around each nominal ratio with offsets slightly wider than the tolerance. This mixes commits, single-period faults and changes of ratio. Directed cases cover the exact edges of the windows and a stopped word clock.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = 3;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_NONE = 3'd7;

  // Nominal clocks per sample: even codes are 128*2^k, odd codes 192*2^k
  function automatic int ratio_nominal(int idx);
    return ((idx % 2) != 0 ? 192 : 128) << (idx / 2);
  endfunction

  // Codes below this value select the reduced oversampling factor
  localparam int HIGH_RATE_CODES = 2;
endpackage

// File: rtl/wclk_sync.sv
module wclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] meas,
  output logic             meas_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= CNT_MAX;
      meas       <= CNT_MAX;
      meas_valid <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      if (rise) begin
        meas       <= cnt;
        meas_valid <= 1'b1;
        cnt        <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_PRE) begin
          meas       <= CNT_MAX;
          meas_valid <= 1'b1;
        end
      end
    end
  end

  // R7: once saturated, the count stays put until a word-clock edge
  p_saturate_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !rise) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
  import clkratio_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] meas,
  output code_t            cls
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(ratio_nominal(g) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(ratio_nominal(g) + TOL);
    assign hit[g] = (meas >= LO) && (meas <= HI);
  end

  always_comb begin
    cls = CODE_NONE;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hit[i]) cls = CODE_W'(i);
  end

  // R3: tolerance windows never overlap
  p_single_window_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
  import clkratio_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  meas_valid,
  input  code_t cls,
  output code_t ratio_code,
  output logic  high_rate,
  output logic  locked,
  output logic  mute_req
);
  code_t prev_cls;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cls   <= CODE_NONE;
      ratio_code <= CODE_NONE;
      high_rate  <= 1'b0;
      locked     <= 1'b0;
      mute_req   <= 1'b1;
    end else if (meas_valid) begin
      prev_cls <= cls;
      if (cls != CODE_NONE && cls == prev_cls) begin
        ratio_code <= cls;
        high_rate  <= (int'(cls) < HIGH_RATE_CODES);
        locked     <= 1'b1;
        mute_req   <= 1'b0;
      end else begin
        locked   <= 1'b0;
        mute_req <= 1'b1;
      end
    end
  end

  // R4: a period that fits no ratio drops lock and mutes
  p_fault_mutes_r4: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && cls == CODE_NONE) |=> (!locked && mute_req));
  // R5: lock appears only on a measurement
  p_lock_on_meas_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(meas_valid));
  // R5: never locked and muted together
  p_lock_unmutes_r5: assert property (@(posedge clk) disable iff (rst)
    locked |-> !mute_req);
  // R2: a locked code is always a real ratio
  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    locked |-> (int'(ratio_code) < NUM_RATIOS));
  // R6: the high-rate flag only goes with the two fastest codes
  p_high_rate_code_r6: assert property (@(posedge clk) disable iff (rst)
    high_rate |-> (int'(ratio_code) < HIGH_RATE_CODES));
endmodule

// File: rtl/clkratio_detector.sv
module clkratio_detector
  import clkratio_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wclk_in,
  output logic [2:0]  ratio_code,
  output logic        high_rate,
  output logic        locked,
  output logic        mute_req
);
  logic             rise;
  logic [CNT_W-1:0] meas;
  logic             meas_valid;
  code_t            cls;
  code_t            code_q;

  wclk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(wclk_in), .rise(rise)
  );

  period_counter #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rst(rst), .rise(rise), .meas(meas), .meas_valid(meas_valid)
  );

  ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) i_class (
    .clk(clk), .rst(rst), .meas(meas), .cls(cls)
  );

  lock_tracker i_lock (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .cls(cls),
    .ratio_code(code_q), .high_rate(high_rate), .locked(locked),
    .mute_req(mute_req)
  );

  assign ratio_code = code_q;

  // R8: the committed code changes only on a lock (commit) cycle
  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !locked |-> $stable(ratio_code));
endmodule

// File: tb/test_clkratio_detector.sv
module test_clkratio_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wclk_in = 1'b0;
  logic [2:0] ratio_code;
  logic high_rate, locked, mute_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int m_prev = 7, m_code = 7;
  bit m_lock = 0, m_mute = 1, m_hr = 0;
  int cur_len = 0;
  bit have_len = 0;

  always #5 clk = ~clk;

  clkratio_detector i_clkratio_detector (
    .clk(clk), .rst(rst), .wclk_in(wclk_in), .ratio_code(ratio_code),
    .high_rate(high_rate), .locked(locked), .mute_req(mute_req)
  );

  function automatic int classify(int n);
    int noms [6] = '{128, 192, 256, 384, 512, 768};
    for (int i = 0; i < 6; i++)
      if (n >= noms[i] - 8 && n <= noms[i] + 8) return i;
    return 7;
  endfunction

  task automatic apply_event(int n);
    int c = classify(n);
    if (c != 7 && c == m_prev) begin
      m_code = c; m_hr = (c < 2); m_lock = 1; m_mute = 0;
    end else begin
      m_lock = 0; m_mute = 1;
    end
    m_prev = c;
  endtask

  task automatic check(string tag);
    checks++;
    if (ratio_code !== 3'(m_code) || high_rate !== m_hr ||
        locked !== m_lock || mute_req !== m_mute) begin
      fails++;
      $display("FAIL %s: got code=%0d hr=%0b lock=%0b mute=%0b, expected code=%0d hr=%0b lock=%0b mute=%0b",
               tag, ratio_code, high_rate, locked, mute_req,
               m_code, m_hr, m_lock, m_mute);
    end
  endtask

  // one word-clock period of n master clocks, checked 6 clocks after its rise
  task automatic period(int n, string tag);
    int hi = n / 2;
    @(negedge clk) wclk_in = 1'b1;
    apply_event(have_len ? cur_len : 1023);
    cur_len = n; have_len = 1;
    repeat (6) @(negedge clk);
    check(tag);
    repeat (hi - 7) @(negedge clk);
    wclk_in = 1'b0;
    repeat (n - hi) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");

    period(256, "R7");    // first edge closes a saturated period
    period(256, "R5");    // one good period: not committed yet
    period(256, "R5");    // second agreeing period commits code 2
    period(384, "R2");
    period(384, "R5");    // lone different class dropped lock
    period(264, "R2");    // 384 commits code 3
    period(264, "R3");
    period(248, "R3");    // 264 and 248 both map to 256
    period(265, "R3");
    period(265, "R4");    // 265 is outside every window
    period(120, "R8");    // unlocked: code held at 2
    period(120, "R4");
    period(119, "R6");    // 120,120 commit code 0 with high rate
    period(200, "R4");
    period(184, "R3");
    period(776, "R6");    // 200,184 commit code 1
    period(776, "R2");
    period(777, "R2");    // code 5 committed
    period(512, "R4");
    period(512, "R4");
    period(512, "R2");
    // stopped word clock
    repeat (1100) @(negedge clk);
    apply_event(1023); have_len = 0;
    check("R7");
    period(768, "R7");
    period(768, "R8");
    period(768, "R2");

    void'($urandom(32'd1234));
    for (int k = 0; k < 150; k++) begin
      int idx = $urandom_range(0, 5);
      int off = $urandom_range(0, 24);
      int noms [6] = '{128, 192, 256, 384, 512, 768};
      period(noms[idx] + off - 12, "R3");
    end
    period(300, "R4");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule